// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block connects a synchronous host request port to an asynchronous DRAM. The DRAM has a shared, time-multiplexed address bus and active-low row strobe, column strobe, write enable and output enable. Each host request carries a flat address. The upper field of that address becomes the row, and the lower field becomes the column. The controller puts the row on the bus and lowers the row strobe. After a programmable delay it puts the column on the bus and pulses the column strobe for a programmable width. Write data is driven toward the memory only during write column cycles. Read data is sampled while the column strobe is still low and is handed back as a one-cycle response.

After an access the row stays open. A later request to the same row costs only a column setup and a column pulse. A request to a different row first closes the open row and waits out a programmable precharge time, then opens the new row. A free-running timer raises a refresh demand once per interval. The default interval is 31250 cycles, which gives about 125 us at 250 MHz, so that 512 rows are visited every 64 ms. A pending refresh wins over new host requests. The controller closes any open row, precharges, lowers the column strobe one cycle ahead of the row strobe, holds both low for a programmable time and precharges again. The address bus carries no meaning during refresh, because the memory steps its own internal row counter.

Top module: `pgdram_ctrl`

## Requirements
- R1: In and right after reset, the row strobe, column strobe, write enable and output enable are all high, the data bus drive enable is 0, and req_ready is 1.
- R2: On a row open, the row strobe falls while dram_addr holds req_addr[17:9]. The column strobe then falls while dram_addr holds req_addr[8:0]. At least T_RCD cycles separate the row strobe fall from that first column strobe fall.
- R3: On a write column pulse, write enable is low and the drive enable is 1 with dram_dq_out equal to the request's write data. On a read, write enable is high, the drive enable is 0, and output enable is low only while the column strobe is low.
- R4: Each read produces exactly one rsp_valid pulse of one cycle. rsp_rdata then holds the data the memory returned for that address, and responses come back in request order.
- R5: A request to the row that is already open causes no row strobe edge. It is served by a new column address and column pulse alone.
- R6: Before every row strobe fall, whether for an access or a refresh, the row strobe has been high for at least T_RP cycles.
- R7: Every column strobe pulse of a host access is low for exactly T_CAS cycles.
- R8: In a refresh, the column strobe is already low at least one cycle before the row strobe falls. The drive enable stays 0 and write enable stays high.
- R9: Refresh cycles recur every REF_CYC cycles, within the length of one in-flight access plus the close sequence. While refresh is pending or running, req_ready is 0.
- R10: req_ready drops in the cycle after a request is accepted. It stays low until that access's column pulse has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address: row in the upper field, column in the lower field |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out; 0 means the bus is released |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench aims at page hits that follow a write, misses between neighbouring rows, the highest row and column, and refresh demands that arrive while a row is open or the controller is idle. A controller that mishandled hits would show extra row strobe falls. One that shortened precharge or the row-to-column delay would break the measured high and delay windows. One that ordered the refresh strobes wrongly would open a row with a stale address and miss the refresh count. Reads are scored against an independent model of the memory. A capture taken after the column strobe rose, or a missing response, would show up as a data mismatch or a leftover queue entry.

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 4,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 2,
  parameter int T_RFR   = 3,
  parameter int REF_CYC = 31250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_RP > T_RFR) ? T_RP : T_RFR;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(REF_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ROWSET, S_RAS, S_COLSET, S_CAS, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } st_t;

  typedef enum logic [1:0] { G_ROW, G_REF, G_IDLE } tgt_t;

  st_t               state;
  tgt_t              tgt;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     ref_cnt;
  logic              ref_pend;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_q;
  logic              hit;
  logic              take;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];
  wire             col_ph  = (state == S_COLSET) || (state == S_CAS);

  assign hit       = (req_row == row_q);
  assign req_ready = ((state == S_IDLE) || (state == S_OPEN)) && !ref_pend;
  assign take      = req_valid && req_ready;

  assign dram_ras_n  = !((state == S_RAS) || (state == S_COLSET) || (state == S_CAS) ||
                         (state == S_OPEN) || (state == S_RRAS));
  assign dram_cas_n  = !((state == S_CAS) || (state == S_RCAS) || (state == S_RRAS));
  assign dram_addr   = ((state == S_ROWSET) || (state == S_RAS)) ? MA_W'(row_q) : MA_W'(col_q);
  assign dram_we_n   = !(wr_q && col_ph);
  assign dram_oe_n   = !(!wr_q && (state == S_CAS));
  assign dram_dq_oe  = wr_q && col_ph;
  assign dram_dq_out = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (state == S_RCAS) ref_pend <= 1'b0;
      if (ref_cnt == RW'(REF_CYC - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tgt       <= G_IDLE;
      cnt       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      wr_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        row_q <= req_row;
        col_q <= req_col;
        wd_q  <= req_wdata;
        wr_q  <= req_write;
      end
      case (state)
        S_IDLE: begin
          if (ref_pend) state <= S_RCAS;
          else if (req_valid) state <= S_ROWSET;
        end
        S_ROWSET: begin
          state <= S_RAS;
          cnt   <= CW'(T_RCD - 1);
        end
        S_RAS: begin
          if (cnt == '0) state <= S_COLSET;
          else cnt <= cnt - 1'b1;
        end
        S_COLSET: begin
          state <= S_CAS;
          cnt   <= CW'(T_CAS - 1);
        end
        S_CAS: begin
          if (cnt == '0) begin
            state <= S_OPEN;
            if (!wr_q) begin
              rsp_rdata <= dram_dq_in;
              rsp_valid <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_OPEN: begin
          if (ref_pend) begin
            state <= S_PRE;
            tgt   <= G_REF;
            cnt   <= CW'(T_RP - 1);
          end else if (req_valid) begin
            if (hit) begin
              state <= S_COLSET;
            end else begin
              state <= S_PRE;
              tgt   <= G_ROW;
              cnt   <= CW'(T_RP - 1);
            end
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            case (tgt)
              G_ROW:   state <= S_ROWSET;
              G_REF:   state <= S_RCAS;
              default: state <= S_IDLE;
            endcase
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RCAS: begin
          state <= S_RRAS;
          cnt   <= CW'(T_RFR - 1);
        end
        S_RRAS: begin
          if (cnt == '0) begin
            state <= S_PRE;
            tgt   <= G_IDLE;
            cnt   <= CW'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_col_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

  a_r3_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

  a_r3_oe_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (!dram_cas_n && dram_we_n));

  a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r5_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (state == S_OPEN) && hit) |=> !dram_ras_n);

  a_r6_pre_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);

  a_r8_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

  a_r8_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> (!dram_dq_oe && dram_we_n));

  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

endmodule

// File: tb/tb_pgdram_ctrl.sv
module tb_pgdram_ctrl;
  localparam int ROW_W = 9, COL_W = 9, DATA_W = 4;
  localparam int T_RCD = 3, T_CAS = 2, T_RP = 2, T_RFR = 3, REF_CYC = 400;
  localparam int SLACK = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [8:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #2 clk = ~clk;

  pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RFR(T_RFR), .REF_CYC(REF_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0, cyc = 0;
  logic [3:0] mem [int];
  logic [3:0] shadow [int];
  logic [3:0] q [$];
  logic [3:0] rd_val = '0;
  bit cur_wr = 0;
  logic [17:0] cur_addr = '0;
  logic [3:0] cur_data = '0;
  int opens = 0, refs = 0, last_ref = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? rd_val : 4'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  bit p_ras = 1, p_cas = 1, ref_cyc_on = 0, need_rcd = 0;
  int hi_len = 1000, since_ras = 0, cas_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        chk(hi_len >= T_RP, "R6 precharge high cycles", hi_len, T_RP);
        if (!dram_cas_n) begin
          chk(!p_cas, "R8 cas low before ras", p_cas, 0);
          chk(!dram_dq_oe && dram_we_n, "R8 refresh quiet bus", dram_dq_oe, 0);
          chk(!req_ready, "R9 ready low in refresh", req_ready, 0);
          if (last_ref >= 0)
            chk((cyc - last_ref) <= REF_CYC + SLACK && (cyc - last_ref) >= REF_CYC - SLACK,
                "R9 refresh interval", cyc - last_ref, REF_CYC);
          last_ref = cyc;
          refs++;
          ref_cyc_on = 1;
        end else begin
          chk(dram_addr == cur_addr[17:9], "R2 row on bus", dram_addr, cur_addr[17:9]);
          opens++;
          need_rcd = 1;
          ref_cyc_on = 0;
        end
        since_ras = 0;
      end
      if (!p_ras && dram_ras_n) hi_len = 1;
      else if (dram_ras_n) hi_len++;
      if (!dram_ras_n) since_ras++;

      if (p_cas && !dram_cas_n && !dram_ras_n) begin
        chk(dram_addr == cur_addr[8:0], "R2 column on bus", dram_addr, cur_addr[8:0]);
        if (need_rcd) chk(since_ras >= T_RCD, "R2 ras to cas delay", since_ras, T_RCD);
        need_rcd = 0;
        cas_len = 0;
        if (cur_wr) begin
          chk(dram_dq_oe && !dram_we_n && dram_dq_out == cur_data, "R3 write drive",
              dram_dq_out, cur_data);
          mem[int'(cur_addr)] = dram_dq_out;
        end else begin
          chk(!dram_dq_oe && dram_we_n && !dram_oe_n, "R3 read strobes", dram_dq_oe, 0);
          rd_val = mem.exists(int'(cur_addr)) ? mem[int'(cur_addr)] : 4'h0;
        end
      end
      if (!dram_cas_n) cas_len++;
      if (!p_cas && dram_cas_n && !ref_cyc_on)
        chk(cas_len == T_CAS, "R7 cas width", cas_len, T_CAS);
      if (dram_cas_n) chk(dram_oe_n, "R3 oe only with cas", dram_oe_n, 1);

      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R4 unexpected response", rsp_rdata, -1);
        else begin
          logic [3:0] e;
          e = q.pop_front();
          chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
        end
      end
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
    end
  end

  task automatic xfer(input bit wr, input logic [17:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_data = d;
    if (wr) shadow[int'(a)] = d;
    else q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    int o0;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset", dram_ras_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe, "R1 strobes after reset",
        dram_cas_n, 1);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    xfer(1, 18'h00005, 4'hA);
    o0 = opens;
    xfer(1, 18'h00006, 4'h3);
    xfer(0, 18'h00005, 4'h0);
    xfer(0, 18'h00006, 4'h0);
    chk(opens == o0, "R5 hits add no row open", opens - o0, 0);
    xfer(1, {9'd7, 9'h1FF}, 4'hF);
    xfer(0, {9'd7, 9'h1FF}, 4'h0);
    xfer(0, 18'h00005, 4'h0);
    chk(opens == o0 + 2, "R5 misses reopen row", opens - o0, 2);
    xfer(1, 18'h3FFFF, 4'h5);
    xfer(1, 18'h3FE00, 4'h9);
    xfer(0, 18'h3FFFF, 4'h0);
    xfer(0, 18'h3FE00, 4'h0);
    xfer(0, 18'h00000, 4'h0);

    lf = 16'hACE1;
    for (int i = 0; i < 220; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      xfer(lf[11], {7'd0, lf[1:0], lf[10:2]}, lf[15:12]);
    end
    repeat (1300) @(negedge clk);
    for (int i = 0; i < 8; i++) xfer(0, {7'd0, 2'(i), 9'(i * 3)}, 4'h0);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R4 all reads answered", q.size(), 0);
    chk(refs >= (cyc / REF_CYC) - 1, "R9 refresh count", refs, (cyc / REF_CYC) - 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule